// File: doc/BRIEF.md
# Three-Channel Thermal Threshold Monitor with Hysteresis

This block watches three unsigned 8-bit temperature readings. Each reading is compared against two programmable thresholds: a critical (over-temperature) limit and a warning (high) limit. Each comparison drives its own status flag. A flag sets once the reading goes strictly above its limit. It falls back to zero only when the reading drops strictly below the limit minus the channel's hysteresis value. Between those two points the flag keeps its state, so a reading that wobbles near a threshold does not make the flag toggle.

The six flags are packed into one status byte that can be read through a small register port. A second register of the same layout holds per-flag alarm enables. The alarm output is high while any enabled flag is set. It is registered, so it follows a flag or enable change one clock later. Each channel's flags are evaluated only on cycles where that channel's sample-valid strobe is high. This lets a slow converter update readings at its own pace.

Top module: `thermal_limit_monitor`

## Requirements
- R1: On a cycle with the channel's valid strobe high and a reading strictly greater than that channel's critical limit, the channel's critical flag is 1 after the clock edge.
- R2: On a valid sample, a set critical flag clears when the reading is strictly below (critical limit − hysteresis). For readings from that value up to and including the limit, the flag keeps its previous value.
- R3: The warning flag follows the same rule against the high limit and the same hysteresis value: it sets strictly above the limit, clears strictly below limit − hysteresis, and holds in between.
- R4: When hysteresis exceeds the limit, the clear threshold saturates at 0, so a set flag never clears, even for a reading of 0.
- R5: A flag changes only on a clock edge where its channel's valid strobe is high. Readings presented without the strobe have no effect.
- R6: Status byte (register address 0) layout: critical flags of channels 2, 1 and 0 at bits 7, 6 and 5; warning flags of channels 2, 1 and 0 at bits 3, 2 and 1.
- R7: Writes to address 0 are ignored. Bits 4 and 0 of both registers always read 0.
- R8: The alarm-enable byte (address 1) is writable and reads back with the same bit layout as the status byte, the reserved bits reading 0.
- R9: beep_o is a register. One clock after any flag or enable change, it equals the OR over the six positions of (flag AND enable).
- R10: After reset, all flags, all enable bits and beep_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_vld_i | input | 3 | Per-channel sample-valid strobe |
| temp_i | input | 24 | Readings, channel c at bits [8c+7:8c] |
| ovt_lim_i | input | 24 | Critical limits, same packing |
| high_lim_i | input | 24 | Warning limits, same packing |
| hyst_i | input | 24 | Per-channel hysteresis, same packing |
| reg_addr_i | input | 1 | 0 = status byte, 1 = alarm-enable byte |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| beep_o | output | 1 | Registered alarm output |

## Verification
On every cycle, the bound checker verifies four properties: that a valid sample above a limit leaves the flag set, that a valid sample below the clear point leaves it cleared, that flags stay put without a strobe, and that the alarm equals the previous cycle's gated OR. It also verifies that the reserved bits read zero. Only the bench scenarios can show the exact hold band at its two inclusive endpoints, the saturated clear threshold, the status byte's bit placement, and the ignored status writes. They also cover the enable-write-to-alarm latency, by ramping each channel up through both limits and back down through the hysteresis band.

// File: rtl/thm_pkg.sv
package thm_pkg;
  localparam int REG_W     = 8;
  localparam int OVT_BASE  = 5;  // critical flags, channel c at bit OVT_BASE+c
  localparam int HIGH_BASE = 1;  // warning flags, channel c at bit HIGH_BASE+c
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ALARM  = 1'b1;

  function automatic logic [REG_W-1:0] pack_flags(input logic [2:0] ovt,
                                                  input logic [2:0] high);
    logic [REG_W-1:0] b;
    b = '0;
    for (int c = 0; c < 3; c++) begin
      b[OVT_BASE+c]  = ovt[c];
      b[HIGH_BASE+c] = high[c];
    end
    return b;
  endfunction
endpackage

// File: rtl/thm_flag.sv
module thm_flag #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] lim_i,
  input  logic [TW-1:0] hyst_i,
  output logic          flag_o
);
  logic [TW-1:0] clr_thr;
  logic          flag_d;
  logic          flag_q;

  // clear point saturates at zero
  always_comb begin
    clr_thr = (lim_i >= hyst_i) ? (lim_i - hyst_i) : '0;
  end

  always_comb begin
    flag_d = flag_q;
    if (temp_i > lim_i)        flag_d = 1'b1;
    else if (temp_i < clr_thr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (sample_en_i) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/thm_regs.sv
module thm_regs
  import thm_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [NCH-1:0]   ovt_i,
  input  logic [NCH-1:0]   high_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] alarm_en_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] impl_mask;
  logic [REG_W-1:0] en_d;
  logic [REG_W-1:0] en_q;
  logic             en_load;

  always_comb begin
    impl_mask = '0;
    status_o  = '0;
    for (int c = 0; c < NCH; c++) begin
      impl_mask[OVT_BASE+c]  = 1'b1;
      impl_mask[HIGH_BASE+c] = 1'b1;
      status_o[OVT_BASE+c]   = ovt_i[c];
      status_o[HIGH_BASE+c]  = high_i[c];
    end
  end

  assign en_load = wr_i && (addr_i == ADDR_ALARM);
  assign en_d    = wdata_i & impl_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_load) en_q <= en_d;
  end

  assign alarm_en_o = en_q;
  assign rdata_o    = (addr_i == ADDR_STATUS) ? status_o : en_q;
endmodule

// File: rtl/thm_alarm.sv
module thm_alarm #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] flags_i,
  input  logic [RW-1:0] en_i,
  output logic          beep_o
);
  logic beep_d;
  logic beep_q;

  always_comb beep_d = |(flags_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beep_q <= 1'b0;
    else        beep_q <= beep_d;
  end

  assign beep_o = beep_q;
endmodule

// File: rtl/thermal_limit_monitor.sv
module thermal_limit_monitor
  import thm_pkg::*;
#(
  parameter int NCH = 3,
  parameter int TW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    temp_vld_i,
  input  logic [NCH*TW-1:0] temp_i,
  input  logic [NCH*TW-1:0] ovt_lim_i,
  input  logic [NCH*TW-1:0] high_lim_i,
  input  logic [NCH*TW-1:0] hyst_i,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              beep_o
);
  logic [NCH-1:0]   ovt_q;
  logic [NCH-1:0]   high_q;
  logic [REG_W-1:0] status_byte;
  logic [REG_W-1:0] alarm_en;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    thm_flag #(.TW(TW)) u_ovt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en_i(temp_vld_i[c]),
      .temp_i     (temp_i[c*TW +: TW]),
      .lim_i      (ovt_lim_i[c*TW +: TW]),
      .hyst_i     (hyst_i[c*TW +: TW]),
      .flag_o     (ovt_q[c])
    );
    thm_flag #(.TW(TW)) u_high (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en_i(temp_vld_i[c]),
      .temp_i     (temp_i[c*TW +: TW]),
      .lim_i      (high_lim_i[c*TW +: TW]),
      .hyst_i     (hyst_i[c*TW +: TW]),
      .flag_o     (high_q[c])
    );
  end

  thm_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ovt_i     (ovt_q),
    .high_i    (high_q),
    .status_o  (status_byte),
    .alarm_en_o(alarm_en),
    .rdata_o   (reg_rdata_o)
  );

  thm_alarm #(.RW(REG_W)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags_i(status_byte),
    .en_i   (alarm_en),
    .beep_o (beep_o)
  );
endmodule

// File: rtl/thm_checker.sv
module thm_checker #(
  parameter int NCH = 3,
  parameter int TW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    temp_vld_i,
  input logic [NCH*TW-1:0] temp_i,
  input logic [NCH*TW-1:0] ovt_lim_i,
  input logic [NCH*TW-1:0] high_lim_i,
  input logic [NCH*TW-1:0] hyst_i,
  input logic [7:0]        reg_rdata_o,
  input logic              beep_o,
  input logic [NCH-1:0]    ovt_q,
  input logic [NCH-1:0]    high_q,
  input logic [7:0]        alarm_en
);
  logic gated;
  always_comb begin
    gated = 1'b0;
    for (int c = 0; c < NCH; c++)
      gated = gated | (ovt_q[c] & alarm_en[5+c]) | (high_q[c] & alarm_en[1+c]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic [TW-1:0] t, lo, lh, hy;
    assign t  = temp_i[c*TW +: TW];
    assign lo = ovt_lim_i[c*TW +: TW];
    assign lh = high_lim_i[c*TW +: TW];
    assign hy = hyst_i[c*TW +: TW];

    p_ovt_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld_i[c] && t > lo) |=> ovt_q[c]);
    p_ovt_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld_i[c] && lo >= hy && t < lo - hy) |=> !ovt_q[c]);
    p_high_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_vld_i[c] && t > lh) |=> high_q[c]);
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !temp_vld_i[c] |=> ($stable(ovt_q[c]) && $stable(high_q[c])));
  end

  p_beep_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (beep_o == $past(gated)));

  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[4] == 1'b0) && (reg_rdata_o[0] == 1'b0));
endmodule

bind thermal_limit_monitor thm_checker #(.NCH(NCH), .TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .temp_vld_i (temp_vld_i),
  .temp_i     (temp_i),
  .ovt_lim_i  (ovt_lim_i),
  .high_lim_i (high_lim_i),
  .hyst_i     (hyst_i),
  .reg_rdata_o(reg_rdata_o),
  .beep_o     (beep_o),
  .ovt_q      (ovt_q),
  .high_q     (high_q),
  .alarm_en   (alarm_en)
);

// File: tb/thermal_limit_monitor_tb.sv
module thermal_limit_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  temp_vld;
  logic [23:0] temp, ovt_lim, high_lim, hyst;
  logic        reg_addr, reg_wr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        beep;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_ovt [3];
  bit m_high[3];

  always #5 clk = ~clk;

  thermal_limit_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .temp_vld_i(temp_vld), .temp_i(temp),
    .ovt_lim_i(ovt_lim), .high_lim_i(high_lim), .hyst_i(hyst),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .beep_o(beep)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    logic [7:0] b = '0;
    for (int c = 0; c < 3; c++) begin
      b[5+c] = m_ovt[c];
      b[1+c] = m_high[c];
    end
    return b;
  endfunction

  function automatic bit next_flag(bit cur, int t, int lim, int hy);
    int thr = (lim >= hy) ? lim - hy : 0;
    if (t > lim) return 1'b1;
    if (t < thr) return 1'b0;
    return cur;
  endfunction

  task automatic read_reg(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic sample(input int ch, input int t);
    temp[ch*8 +: 8] = t[7:0];
    temp_vld[ch] = 1'b1;
    @(negedge clk);
    temp_vld[ch] = 1'b0;
    m_ovt[ch]  = next_flag(m_ovt[ch],  t, int'(ovt_lim[ch*8 +: 8]),  int'(hyst[ch*8 +: 8]));
    m_high[ch] = next_flag(m_high[ch], t, int'(high_lim[ch*8 +: 8]), int'(hyst[ch*8 +: 8]));
  endtask

  task automatic expect_status(input string req);
    logic [7:0] d;
    read_reg(1'b0, d);
    check(req, d, exp_status());
  endtask

  task automatic t_reset();
    logic [7:0] d;
    read_reg(1'b0, d); check("R10 status", d, 8'h00);
    read_reg(1'b1, d); check("R10 enables", d, 8'h00);
    check("R10 beep", {7'd0, beep}, 8'h00);
  endtask

  // ramp up through both limits and back down; limits 90/70, hysteresis 5
  task automatic t_ramp(input int ch);
    logic [7:0] d;
    for (int t = 60; t <= 100; t++) begin
      sample(ch, t);
      read_reg(1'b0, d);
      if (t == 70) check("R3 hold at high limit", d[1+ch], 1'b0);
      if (t == 71) check("R3 set above high limit", d[1+ch], 1'b1);
      if (t == 90) check("R1 hold at critical limit", d[5+ch], 1'b0);
      if (t == 91) check("R1 set above critical limit", d[5+ch], 1'b1);
      check("R6 layout up", d, exp_status());
    end
    for (int t = 100; t >= 55; t--) begin
      sample(ch, t);
      read_reg(1'b0, d);
      if (t == 85) check("R2 hold at clear point", d[5+ch], 1'b1);
      if (t == 84) check("R2 clear below band", d[5+ch], 1'b0);
      if (t == 65) check("R3 hold at clear point", d[1+ch], 1'b1);
      if (t == 64) check("R3 clear below band", d[1+ch], 1'b0);
      check("R6 layout down", d, exp_status());
    end
    check("R9 beep masked during ramp", {7'd0, beep}, 8'h00);
  endtask

  task automatic t_no_strobe();
    sample(0, 95);
    expect_status("R5 setup");
    temp[7:0] = 8'd10;
    repeat (3) @(negedge clk);
    expect_status("R5 no strobe keeps flags");
    check("R5 flag still set", {7'd0, exp_status()[5]}, 8'h01);
    sample(0, 10);
    expect_status("R5 strobe clears");
  endtask

  task automatic t_saturate();
    logic [7:0] d;
    ovt_lim[15:8] = 8'd3; hyst[15:8] = 8'd10;
    sample(1, 4);
    read_reg(1'b0, d); check("R4 set", d[6], 1'b1);
    sample(1, 0);
    read_reg(1'b0, d); check("R4 reading 0 keeps flag", d[6], 1'b1);
    ovt_lim[15:8] = 8'd90; hyst[15:8] = 8'd5;
    sample(1, 0);
    read_reg(1'b0, d); check("R4 restore clears", d[6], 1'b0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    sample(2, 80);           // warning flag ch2 -> bit 3
    write_reg(1'b0, 8'hFF);
    read_reg(1'b0, d); check("R7 status write ignored", d, 8'h08);
    write_reg(1'b1, 8'hFF);
    read_reg(1'b1, d); check("R8 enable readback masked", d, 8'hEE);
    write_reg(1'b1, 8'h00);
    read_reg(1'b1, d); check("R8 enable cleared", d, 8'h00);
    sample(2, 50);
  endtask

  task automatic t_beep();
    sample(1, 75);           // warning flag ch1 -> bit 2
    write_reg(1'b1, 8'h20);  // enable only ch0 critical
    @(negedge clk);
    check("R9 gated off", {7'd0, beep}, 8'h00);
    write_reg(1'b1, 8'h04);
    check("R9 one cycle lag", {7'd0, beep}, 8'h00);
    @(negedge clk);
    check("R9 beep on", {7'd0, beep}, 8'h01);
    sample(1, 60);
    check("R9 flag clear lag", {7'd0, beep}, 8'h01);
    @(negedge clk);
    check("R9 beep off", {7'd0, beep}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; temp_vld = '0; temp = '0;
    ovt_lim = {3{8'd90}}; high_lim = {3{8'd70}}; hyst = {3{8'd5}};
    reg_addr = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    for (int c = 0; c < 3; c++) begin m_ovt[c] = 0; m_high[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int c = 0; c < 3; c++) t_ramp(c);
    t_no_strobe();
    t_saturate();
    t_regs();
    t_beep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule